// File: doc/BRIEF.md
# Compressed Cache Set Space Allocator

This block manages the data space of a single set in a cache that can hold compressed lines. The set's data area is a pool of 32 segments of 8 bytes each. A line takes 1 to 8 segments: 8 when stored uncompressed and 1 to 7 when compressed. The set has 8 tag slots, so up to 8 lines can be resident, while only 4 uncompressed lines fit. Each tag slot records whether it is valid, how many segments its line holds, where the line starts, and whether it is compressed.

An allocation request carries a segment count. The block evicts lines in least-recently-used order, one per cycle, until there are enough free segments and a free tag slot. If the free space above the highest resident line is too small, it then compacts the survivors toward segment 0, one line per cycle, and reports each move so the data array can copy the data. Finally it places the new line at the top of the packed region and makes it most recently used. It then pulses done with the chosen slot and offset. A touch input lets the cache mark a hit line as most recently used. The data array, the compressor and the decision whether to compress all sit outside this block.

Top module: `scc_set_alloc`

## Requirements
- R1: After reset every tag slot is invalid, `busy_o` is low, and `done_o`, `err_o`, `evict_o` and `move_o` are low.
- R2: In idle, a request with a size of 0 or greater than 8 produces a one-cycle `err_o` pulse one cycle later. It raises neither busy nor done and changes no slot state.
- R3: Each valid slot reports its segment count on `slot_size_o`. It reports `slot_cmp_o` as 1 exactly when that count is below 8.
- R4: Suppose a request fits in the free segments, a tag slot is free, and the space above the highest resident line holds the new line. Then nothing is evicted or moved. The new line goes to the lowest-numbered free slot at the offset just above the highest resident line.
- R5: When the free segments are fewer than requested, or all 8 slots are valid, the least-recently-used line is evicted. Only one line is evicted per cycle, and eviction continues until both conditions are met. Each eviction pulses `evict_o` with the slot number on `evict_slot_o`.
- R6: A newly placed line becomes most recently used. A one-cycle `touch_i` in idle, without a request, makes a valid slot most recently used. A touch of an invalid slot has no effect.
- R7: When the space above the highest resident line is still too small after eviction, the resident lines are packed contiguously from segment 0. They keep their original relative offset order and move one per cycle. A line whose offset changes pulses `move_o` with its slot and old and new offsets, and every move goes to a lower offset.
- R8: `busy_o` is high from the cycle after a request is accepted until `done_o` pulses. Requests that arrive while busy are ignored.
- R9: Valid lines never overlap in the segment pool, and their sizes never add up to more than 32.
- R10: `done_o` pulses for one cycle with `alloc_slot_o` and `alloc_off_o`. The reported slot is valid and its reported offset equals `alloc_off_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Allocation request strobe, sampled in idle |
| req_size_i | input | 4 | Requested segment count |
| touch_i | input | 1 | Mark a slot most recently used |
| touch_slot_i | input | 3 | Slot to touch |
| busy_o | output | 1 | Allocation in progress |
| done_o | output | 1 | Allocation complete pulse |
| err_o | output | 1 | Illegal size pulse |
| alloc_slot_o | output | 3 | Slot given to the new line |
| alloc_off_o | output | 5 | First segment of the new line |
| evict_o | output | 1 | Eviction notice pulse |
| evict_slot_o | output | 3 | Evicted slot |
| move_o | output | 1 | Compaction move pulse |
| move_slot_o | output | 3 | Slot being moved |
| move_from_o | output | 5 | Old first segment |
| move_to_o | output | 5 | New first segment |
| slot_valid_o | output | 8 | Per-slot valid |
| slot_cmp_o | output | 8 | Per-slot compressed flag |
| slot_size_o | output | 32 | Per-slot segment count, 4 bits each |
| slot_off_o | output | 40 | Per-slot first segment, 5 bits each |

## Verification
The assertions check these properties on every cycle:
- valid lines never overlap and fit within the pool;
- moves only go downward;
- error and done never pulse together, and an error leaves the slots untouched;
- busy falls only with done;
- the slot reported by done is valid and holds the reported offset.

Only the bench's directed scenarios can show the following:
- which line is chosen for eviction, because this depends on the LRU history, including touches;
- how many evictions and moves a request triggers;
- the exact offsets after packing;
- that a request made while busy is dropped.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EVICT   = 2'd1,
    ST_COMPACT = 2'd2,
    ST_ALLOC   = 2'd3
  } alloc_state_e;
endpackage

// File: rtl/scc_lru_stack.sv
// Recency stack: entry 0 is least recent, entry cnt-1 is most recent.
module scc_lru_stack #(
  parameter int NUM_TAGS = 8,
  localparam int ID_W  = $clog2(NUM_TAGS),
  localparam int CNT_W = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [ID_W-1:0]  push_id_i,
  input  logic             pop_i,
  input  logic             touch_i,
  input  logic [ID_W-1:0]  touch_id_i,
  output logic [ID_W-1:0]  lru_id_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ID_W-1:0]  stk_q [NUM_TAGS];
  logic [ID_W-1:0]  stk_n [NUM_TAGS];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             hit;

  always_comb begin
    stk_n = stk_q;
    cnt_n = cnt_q;
    hit   = 1'b0;
    if (pop_i) begin
      for (int i = 0; i < NUM_TAGS - 1; i++) stk_n[i] = stk_q[i+1];
      stk_n[NUM_TAGS-1] = '0;
      cnt_n = cnt_q - CNT_W'(1);
    end else if (push_i) begin
      for (int i = 0; i < NUM_TAGS; i++)
        if (CNT_W'(i) == cnt_q) stk_n[i] = push_id_i;
      cnt_n = cnt_q + CNT_W'(1);
    end else if (touch_i) begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (CNT_W'(i) < cnt_q) begin
          if (stk_q[i] == touch_id_i) hit = 1'b1;
          if (hit && (CNT_W'(i + 1) < cnt_q)) stk_n[i] = stk_q[(i+1) % NUM_TAGS];
          if (hit && (CNT_W'(i + 1) == cnt_q)) stk_n[i] = touch_id_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < NUM_TAGS; i++) stk_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      stk_q <= stk_n;
    end
  end

  assign lru_id_o = stk_q[0];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/scc_slot_scan.sv
// Combinational scans over the tag slots.
module scc_slot_scan #(
  parameter int NUM_TAGS = 8,
  parameter int SZ_W     = 4,
  parameter int OFF_W    = 5,
  parameter int END_W    = 6,
  localparam int ID_W    = $clog2(NUM_TAGS)
) (
  input  logic [NUM_TAGS-1:0]            valid_i,
  input  logic [NUM_TAGS-1:0][SZ_W-1:0]  size_i,
  input  logic [NUM_TAGS-1:0][OFF_W-1:0] off_i,
  input  logic [NUM_TAGS-1:0]            placed_i,
  output logic                           free_found_o,
  output logic [ID_W-1:0]                free_id_o,
  output logic [END_W-1:0]               hi_o,
  output logic                           low_found_o,
  output logic [ID_W-1:0]                low_id_o
);
  logic [END_W-1:0] line_end [NUM_TAGS];
  logic [OFF_W-1:0] best_off;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_end
    assign line_end[g] = END_W'(off_i[g]) + END_W'(size_i[g]);
  end

  always_comb begin
    free_found_o = 1'b0;
    free_id_o    = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found_o = 1'b1;
        free_id_o    = ID_W'(i);
      end
    end
  end

  always_comb begin
    hi_o = '0;
    for (int i = 0; i < NUM_TAGS; i++)
      if (valid_i[i] && line_end[i] > hi_o) hi_o = line_end[i];
  end

  // lowest-offset valid line not yet packed
  always_comb begin
    low_found_o = 1'b0;
    low_id_o    = '0;
    best_off    = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (valid_i[i] && !placed_i[i] && (!low_found_o || off_i[i] < best_off)) begin
        low_found_o = 1'b1;
        low_id_o    = ID_W'(i);
        best_off    = off_i[i];
      end
    end
  end
endmodule

// File: rtl/scc_set_alloc.sv
module scc_set_alloc
  import scc_pkg::*;
#(
  parameter int NUM_SEGS      = 32,
  parameter int NUM_TAGS      = 8,
  parameter int MAX_LINE_SEGS = 8,
  localparam int ID_W  = $clog2(NUM_TAGS),
  localparam int OFF_W = $clog2(NUM_SEGS),
  localparam int END_W = $clog2(NUM_SEGS + 1),
  localparam int SZ_W  = $clog2(2 * MAX_LINE_SEGS),
  localparam int CNT_W = $clog2(NUM_TAGS + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  input  logic [SZ_W-1:0]                req_size_i,
  input  logic                           touch_i,
  input  logic [ID_W-1:0]                touch_slot_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           err_o,
  output logic [ID_W-1:0]                alloc_slot_o,
  output logic [OFF_W-1:0]               alloc_off_o,
  output logic                           evict_o,
  output logic [ID_W-1:0]                evict_slot_o,
  output logic                           move_o,
  output logic [ID_W-1:0]                move_slot_o,
  output logic [OFF_W-1:0]               move_from_o,
  output logic [OFF_W-1:0]               move_to_o,
  output logic [NUM_TAGS-1:0]            slot_valid_o,
  output logic [NUM_TAGS-1:0]            slot_cmp_o,
  output logic [NUM_TAGS-1:0][SZ_W-1:0]  slot_size_o,
  output logic [NUM_TAGS-1:0][OFF_W-1:0] slot_off_o
);
  alloc_state_e state_q;

  logic [NUM_TAGS-1:0]            valid_q, placed_q;
  logic [NUM_TAGS-1:0][SZ_W-1:0]  size_q;
  logic [NUM_TAGS-1:0][OFF_W-1:0] off_q;
  logic [END_W-1:0]               used_q, pos_q;
  logic [SZ_W-1:0]                req_sz_q;

  logic             bad_size, fits, tail_ok;
  logic             lru_pop, lru_push, lru_touch;
  logic [ID_W-1:0]  lru_id, free_id, low_id;
  logic [CNT_W-1:0] live_cnt;
  logic [END_W-1:0] hi;
  logic             free_found, low_found;

  scc_lru_stack #(.NUM_TAGS(NUM_TAGS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (lru_push),
    .push_id_i  (free_id),
    .pop_i      (lru_pop),
    .touch_i    (lru_touch),
    .touch_id_i (touch_slot_i),
    .lru_id_o   (lru_id),
    .cnt_o      (live_cnt)
  );

  scc_slot_scan #(
    .NUM_TAGS (NUM_TAGS),
    .SZ_W     (SZ_W),
    .OFF_W    (OFF_W),
    .END_W    (END_W)
  ) u_scan (
    .valid_i      (valid_q),
    .size_i       (size_q),
    .off_i        (off_q),
    .placed_i     (placed_q),
    .free_found_o (free_found),
    .free_id_o    (free_id),
    .hi_o         (hi),
    .low_found_o  (low_found),
    .low_id_o     (low_id)
  );

  assign bad_size  = (req_size_i == '0) || (req_size_i > SZ_W'(MAX_LINE_SEGS));
  assign fits      = ((END_W'(NUM_SEGS) - used_q) >= END_W'(req_sz_q)) &&
                     (live_cnt < CNT_W'(NUM_TAGS));
  assign tail_ok   = (END_W'(NUM_SEGS) - hi) >= END_W'(req_sz_q);
  assign lru_pop   = (state_q == ST_EVICT) && !fits;
  assign lru_push  = (state_q == ST_ALLOC);
  assign lru_touch = (state_q == ST_IDLE) && !req_valid_i && touch_i && valid_q[touch_slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      valid_q      <= '0;
      placed_q     <= '0;
      size_q       <= '0;
      off_q        <= '0;
      used_q       <= '0;
      pos_q        <= '0;
      req_sz_q     <= '0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      alloc_slot_o <= '0;
      alloc_off_o  <= '0;
      evict_o      <= 1'b0;
      evict_slot_o <= '0;
      move_o       <= 1'b0;
      move_slot_o  <= '0;
      move_from_o  <= '0;
      move_to_o    <= '0;
    end else begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      evict_o <= 1'b0;
      move_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (bad_size) begin
              err_o <= 1'b1;
            end else begin
              req_sz_q <= req_size_i;
              state_q  <= ST_EVICT;
            end
          end
        end
        ST_EVICT: begin
          if (!fits) begin
            evict_o         <= 1'b1;
            evict_slot_o    <= lru_id;
            valid_q[lru_id] <= 1'b0;
            used_q          <= used_q - END_W'(size_q[lru_id]);
          end else if (tail_ok) begin
            state_q <= ST_ALLOC;
          end else begin
            placed_q <= '0;
            pos_q    <= '0;
            state_q  <= ST_COMPACT;
          end
        end
        ST_COMPACT: begin
          if (low_found) begin
            if (END_W'(off_q[low_id]) != pos_q) begin
              move_o      <= 1'b1;
              move_slot_o <= low_id;
              move_from_o <= off_q[low_id];
              move_to_o   <= pos_q[OFF_W-1:0];
            end
            off_q[low_id]    <= pos_q[OFF_W-1:0];
            placed_q[low_id] <= 1'b1;
            pos_q            <= pos_q + END_W'(size_q[low_id]);
          end else begin
            state_q <= ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          valid_q[free_id] <= 1'b1;
          size_q[free_id]  <= req_sz_q;
          off_q[free_id]   <= hi[OFF_W-1:0];
          used_q           <= used_q + END_W'(req_sz_q);
          done_o           <= 1'b1;
          alloc_slot_o     <= free_id;
          alloc_off_o      <= hi[OFF_W-1:0];
          state_q          <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign slot_valid_o = valid_q;
  assign slot_size_o  = size_q;
  assign slot_off_o   = off_q;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_cmp
    assign slot_cmp_o[g] = valid_q[g] && (size_q[g] < SZ_W'(MAX_LINE_SEGS));
  end

  logic unused_free;
  assign unused_free = free_found;
endmodule

// File: rtl/scc_set_alloc_chk.sv
module scc_set_alloc_chk #(
  parameter int NUM_SEGS = 32,
  parameter int NUM_TAGS = 8,
  parameter int ID_W     = 3,
  parameter int OFF_W    = 5,
  parameter int SZ_W     = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           busy_o,
  input logic                           done_o,
  input logic                           err_o,
  input logic [ID_W-1:0]                alloc_slot_o,
  input logic [OFF_W-1:0]               alloc_off_o,
  input logic                           evict_o,
  input logic                           move_o,
  input logic [OFF_W-1:0]               move_from_o,
  input logic [OFF_W-1:0]               move_to_o,
  input logic [NUM_TAGS-1:0]            slot_valid_o,
  input logic [NUM_TAGS-1:0][SZ_W-1:0]  slot_size_o,
  input logic [NUM_TAGS-1:0][OFF_W-1:0] slot_off_o
);
  logic overlap;
  int   total;

  always_comb begin
    overlap = 1'b0;
    total   = 0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (slot_valid_o[i]) total += int'(slot_size_o[i]);
      for (int j = i + 1; j < NUM_TAGS; j++) begin
        if (slot_valid_o[i] && slot_valid_o[j] &&
            (int'(slot_off_o[i]) < int'(slot_off_o[j]) + int'(slot_size_o[j])) &&
            (int'(slot_off_o[j]) < int'(slot_off_o[i]) + int'(slot_size_o[i])))
          overlap = 1'b1;
      end
    end
  end

  // R2
  err_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && done_o));
  // R2
  err_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(slot_valid_o) && !busy_o));
  // R5
  evict_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |-> busy_o);
  // R7
  move_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    move_o |-> (move_to_o < move_from_o));
  // R8
  busy_ends_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlap);
  // R9
  seg_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total <= NUM_SEGS);
  // R10
  done_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (slot_valid_o[alloc_slot_o] && slot_off_o[alloc_slot_o] == alloc_off_o && !busy_o));
endmodule

bind scc_set_alloc scc_set_alloc_chk #(
  .NUM_SEGS (NUM_SEGS),
  .NUM_TAGS (NUM_TAGS),
  .ID_W     (ID_W),
  .OFF_W    (OFF_W),
  .SZ_W     (SZ_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .alloc_slot_o (alloc_slot_o),
  .alloc_off_o  (alloc_off_o),
  .evict_o      (evict_o),
  .move_o       (move_o),
  .move_from_o  (move_from_o),
  .move_to_o    (move_to_o),
  .slot_valid_o (slot_valid_o),
  .slot_size_o  (slot_size_o),
  .slot_off_o   (slot_off_o)
);

// File: tb/tb_scc_set_alloc.sv
module tb_scc_set_alloc;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [3:0]       req_size = '0;
  logic             touch = 1'b0;
  logic [2:0]       touch_slot = '0;
  logic             busy_o, done_o, err_o, evict_o, move_o;
  logic [2:0]       alloc_slot_o, evict_slot_o, move_slot_o;
  logic [4:0]       alloc_off_o, move_from_o, move_to_o;
  logic [7:0]       slot_valid_o, slot_cmp_o;
  logic [7:0][3:0]  slot_size_o;
  logic [7:0][4:0]  slot_off_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_ev [8];

  always #5 clk = ~clk;

  scc_set_alloc dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_size_i (req_size),
    .touch_i (touch), .touch_slot_i (touch_slot),
    .busy_o (busy_o), .done_o (done_o), .err_o (err_o),
    .alloc_slot_o (alloc_slot_o), .alloc_off_o (alloc_off_o),
    .evict_o (evict_o), .evict_slot_o (evict_slot_o),
    .move_o (move_o), .move_slot_o (move_slot_o),
    .move_from_o (move_from_o), .move_to_o (move_to_o),
    .slot_valid_o (slot_valid_o), .slot_cmp_o (slot_cmp_o),
    .slot_size_o (slot_size_o), .slot_off_o (slot_off_o)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic slot_chk(input string rq, input int s, input int sz, input int off);
    chk(rq, $sformatf("slot%0d valid", s), int'(slot_valid_o[s]), 1);
    chk(rq, $sformatf("slot%0d size", s), int'(slot_size_o[s]), sz);
    chk(rq, $sformatf("slot%0d off", s), int'(slot_off_o[s]), off);
  endtask

  task automatic alloc_run(input string rq, input int sz, input int e_slot, input int e_off,
                           input int e_nev, input int e_nmv, input bit poke);
    int ev_cnt = 0;
    int mv_cnt = 0;
    int cyc = 0;
    bit got = 0;
    bit saw_err = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = 4'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "busy after accept", int'(busy_o), 1);
    if (poke) begin
      req_valid = 1'b1;
      req_size  = 4'd0;
    end
    while (!got && cyc < 300) begin
      if (evict_o) begin
        if (ev_cnt < 8) chk("R5", $sformatf("%s evict #%0d", rq, ev_cnt), int'(evict_slot_o), exp_ev[ev_cnt]);
        ev_cnt++;
      end
      if (move_o) mv_cnt++;
      if (err_o) saw_err = 1;
      if (done_o) got = 1;
      else begin
        @(negedge clk);
        req_valid = 1'b0;
        cyc++;
      end
    end
    chk("R10", {rq, " done seen"}, int'(got), 1);
    chk("R10", {rq, " slot"}, int'(alloc_slot_o), e_slot);
    chk("R10", {rq, " off"}, int'(alloc_off_o), e_off);
    chk("R5", {rq, " eviction count"}, ev_cnt, e_nev);
    chk("R7", {rq, " move count"}, mv_cnt, e_nmv);
    chk("R8", {rq, " busy at done"}, int'(busy_o), 0);
    if (poke) chk("R8", {rq, " request while busy ignored"}, int'(saw_err), 0);
  endtask

  task automatic err_run(input int sz);
    logic [7:0] v0;
    v0 = slot_valid_o;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = 4'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", $sformatf("err pulse size %0d", sz), int'(err_o), 1);
    chk("R2", "no busy on error", int'(busy_o), 0);
    chk("R2", "no done on error", int'(done_o), 0);
    @(negedge clk);
    chk("R2", "err one cycle", int'(err_o), 0);
    chk("R2", "slots unchanged", int'(slot_valid_o), int'(v0));
  endtask

  task automatic touch_run(input int s);
    @(negedge clk);
    touch = 1'b1;
    touch_slot = 3'(s);
    @(negedge clk);
    touch = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "valid after reset", int'(slot_valid_o), 0);
    chk("R1", "busy after reset", int'(busy_o), 0);
    chk("R1", "pulses after reset", int'({done_o, err_o, evict_o, move_o}), 0);
  endtask

  task automatic t_errors();
    err_run(0);
    err_run(9);
    err_run(15);
  endtask

  task automatic t_fill();
    alloc_run("R4 fill0", 8, 0, 0, 0, 0, 0);
    alloc_run("R4 fill1", 8, 1, 8, 0, 0, 0);
    alloc_run("R4 fill2", 8, 2, 16, 0, 0, 0);
    alloc_run("R4 fill3", 3, 3, 24, 0, 0, 0);
    chk("R3", "slot0 uncompressed", int'(slot_cmp_o[0]), 0);
    chk("R3", "slot3 compressed", int'(slot_cmp_o[3]), 1);
    chk("R3", "slot3 size", int'(slot_size_o[3]), 3);
  endtask

  task automatic t_evict_compact();
    exp_ev[0] = 0;
    alloc_run("R7 compact", 8, 0, 19, 1, 3, 0);
    slot_chk("R7", 1, 8, 0);
    slot_chk("R7", 2, 8, 8);
    slot_chk("R7", 3, 3, 16);
    chk("R5", "slot0 valid again", int'(slot_valid_o[0]), 1);
  endtask

  task automatic t_touch();
    touch_run(1);
    exp_ev[0] = 2;
    alloc_run("R6 touch", 8, 2, 19, 1, 2, 0);
    slot_chk("R6", 1, 8, 0);
    slot_chk("R6", 3, 3, 8);
    slot_chk("R6", 0, 8, 11);
  endtask

  task automatic t_tag_limit();
    do_reset();
    for (int i = 0; i < 8; i++) alloc_run("R4 small", 1, i, i, 0, 0, 0);
    exp_ev[0] = 0;
    alloc_run("R5 tag limit", 1, 0, 8, 1, 0, 0);
    exp_ev[0] = 1;
    alloc_run("R5 tag limit b", 8, 1, 9, 1, 0, 0);
    exp_ev[0] = 2;
    alloc_run("R5 tag limit c", 8, 2, 17, 1, 0, 0);
    exp_ev[0] = 3;
    alloc_run("R7 full pack", 8, 3, 21, 1, 7, 0);
    slot_chk("R7", 4, 1, 0);
    slot_chk("R7", 0, 1, 4);
    slot_chk("R7", 1, 8, 5);
    slot_chk("R7", 2, 8, 13);
  endtask

  task automatic t_multi_evict();
    exp_ev[0] = 4; exp_ev[1] = 5; exp_ev[2] = 6; exp_ev[3] = 7; exp_ev[4] = 0;
    alloc_run("R5 multi", 8, 0, 24, 5, 3, 1);
    chk("R5", "slot4 evicted", int'(slot_valid_o[4]), 0);
    slot_chk("R5", 1, 8, 0);
    slot_chk("R5", 2, 8, 8);
    slot_chk("R5", 3, 8, 16);
  endtask

  task automatic t_touch_invalid();
    touch_run(5);
    touch_run(1);
    exp_ev[0] = 2;
    alloc_run("R6 invalid touch", 1, 2, 24, 1, 2, 0);
    chk("R3", "size1 compressed", int'(slot_cmp_o[2]), 1);
    chk("R6", "slot5 still invalid", int'(slot_valid_o[5]), 0);
    slot_chk("R6", 3, 8, 8);
    slot_chk("R6", 0, 8, 16);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_errors();
    t_fill();
    t_evict_compact();
    t_touch();
    t_tag_limit();
    t_multi_evict();
    t_touch_invalid();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule